// File: doc/BRIEF.md
# Eight-Channel ADC Conversion Sequencer

This block is a synchronous controller for an external successive-approximation converter. The converter has eight analog inputs and returns an 8-bit result on a parallel bus. A host asks for a conversion by pulsing a request together with a 3-bit channel number. The block then works through the converter's pin handshake. It puts the channel code on the address lines and lets it settle. It pulses the latch line, then pulses the start line. It waits for the end-of-conversion line to fall and then to rise again. Finally it opens the output-enable window and samples the data bus near the end of that window.

The captured byte and the channel it belongs to stay on the result registers. A one-cycle valid pulse announces each new result. While a conversion is in flight the busy output is high, and any new request is dropped. The end-of-conversion input comes from another clock domain, so it passes through two flops before the block acts on it. If the converter never completes the handshake, a cycle limit ends the wait. The block then raises an error flag and returns to idle with every control line low.

Top module: `adc_seq`

## Requirements
- R1: After reset, latch_o, convst_o, oe_o, busy_o, valid_o and timeout_o are all low.
- R2: addr_o carries the requested channel, bit 0 being the least significant select line, so code 0 selects input 0 and code 7 selects input 7; it stays constant while busy_o is high.
- R3: latch_o rises only after addr_o has been driven for SETUP_CYC cycles, and it stays high for PULSE_CYC cycles.
- R4: convst_o rises only after latch_o has fallen, and it stays high for PULSE_CYC cycles.
- R5: oe_o does not rise until eoc_i has been seen low and has then returned high.
- R6: oe_o stays high for SETTLE_CYC cycles, and data_i is sampled while oe_o is still high.
- R7: valid_o is high for exactly one cycle per conversion. result_o and result_chan_o then hold the sampled byte and its channel until the next capture.
- R8: busy_o is high from the cycle after a request is accepted until valid_o rises, and valid_o is never high together with busy_o. A request made while busy_o is high is ignored.
- R9: If TIMEOUT_CYC cycles pass in the end-of-conversion wait, the block returns to idle with all control outputs low and sets timeout_o. timeout_o is cleared when the next request is accepted.
- R10: After a result or a timeout, a new request starts again from the address phase.
- R11: At most one of latch_o, convst_o and oe_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request |
| chan_i | input | 3 | Channel number for the request |
| busy_o | output | 1 | Conversion in progress |
| addr_o | output | 3 | Channel select lines to the converter |
| latch_o | output | 1 | Address latch strobe |
| convst_o | output | 1 | Start-of-conversion strobe |
| oe_o | output | 1 | Converter output enable |
| eoc_i | input | 1 | End of conversion, asynchronous, idles high |
| data_i | input | 8 | Converter data bus |
| result_o | output | 8 | Last captured byte |
| result_chan_o | output | 3 | Channel of the last captured byte |
| valid_o | output | 1 | One-cycle pulse on a new result |
| timeout_o | output | 1 | End-of-conversion wait aborted |

## Verification
Conversions are run on channels 0, 7 and several values in between. The converter model returns a different byte for each latched address, so a reversed or shifted select line shows up as a wrong result. Conversion times range from one cycle to many. The one-cycle case tests whether the two-phase wait can miss a short low pulse, and the long cases show that the wait lasts exactly as long as the converter needs. Two fault patterns are applied: an end-of-conversion line that never falls, and one that falls and stays low. The first ends the wait in the falling phase and the second in the rising phase. In both, the abort must come after exactly the same number of cycles. A stray request during a conversion must leave the channel and the result unchanged.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int SETTLE_CYC  = 2,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] chan_i,
  output logic       busy_o,
  output logic [2:0] addr_o,
  output logic       latch_o,
  output logic       convst_o,
  output logic       oe_o,
  input  logic       eoc_i,
  input  logic [7:0] data_i,
  output logic [7:0] result_o,
  output logic [2:0] result_chan_o,
  output logic       valid_o,
  output logic       timeout_o
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > SETTLE_CYC) ? SETUP_CYC : SETTLE_CYC) :
                        ((PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC);
  localparam int CW = $clog2(MAXC) + 1;
  localparam int TW = $clog2(TIMEOUT_CYC) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_LATCH, S_START, S_FALL, S_RISE, S_READ
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          eoc_s1, eoc_s2;
  logic          cnt_done, tmo_hit;

  assign cnt_done = (cnt == '0);
  assign tmo_hit  = (tcnt == TW'(TIMEOUT_CYC - 1));
  assign busy_o   = (state != S_IDLE);
  assign latch_o  = (state == S_LATCH);
  assign convst_o = (state == S_START);
  assign oe_o     = (state == S_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc_s1 <= 1'b1;
      eoc_s2 <= 1'b1;
    end else begin
      eoc_s1 <= eoc_i;
      eoc_s2 <= eoc_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      cnt           <= '0;
      tcnt          <= '0;
      addr_o        <= '0;
      result_o      <= '0;
      result_chan_o <= '0;
      valid_o       <= 1'b0;
      timeout_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (state)
        S_IDLE:
          if (start_i) begin
            state     <= S_SETUP;
            addr_o    <= chan_i;
            cnt       <= CW'(SETUP_CYC - 1);
            timeout_o <= 1'b0;
          end
        S_SETUP:
          if (cnt_done) begin
            state <= S_LATCH;
            cnt   <= CW'(PULSE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_LATCH:
          if (cnt_done) begin
            state <= S_START;
            cnt   <= CW'(PULSE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_START:
          if (cnt_done) begin
            state <= S_FALL;
            tcnt  <= '0;
          end else cnt <= cnt - 1'b1;
        S_FALL, S_RISE:
          if (tmo_hit) begin
            state     <= S_IDLE;
            timeout_o <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
            if (state == S_FALL && !eoc_s2) state <= S_RISE;
            if (state == S_RISE && eoc_s2) begin
              state <= S_READ;
              cnt   <= CW'(SETTLE_CYC - 1);
            end
          end
        S_READ:
          if (cnt_done) begin
            state         <= S_IDLE;
            result_o      <= data_i;
            result_chan_o <= addr_o;
            valid_o       <= 1'b1;
          end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ctrl_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({latch_o, convst_o, oe_o}));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_valid_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));

  assert_oe_after_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> eoc_s2);

  assert_start_after_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_o) |-> $fell(latch_o));

  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (!busy_o && !latch_o && !convst_o && !oe_o));
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
  localparam int SETUP_CYC = 2, PULSE_CYC = 3, SETTLE_CYC = 2, TIMEOUT_CYC = 200;
  localparam int NV = 6;
  localparam logic [2:0] VCH [NV] = '{3'd0, 3'd7, 3'd1, 3'd4, 3'd2, 3'd5};
  localparam int VLEN [NV] = '{1, 5, 17, 2, 40, 9};

  logic clk = 0, rst_n = 0, start_i = 0, eoc_i, latch_o, convst_o, oe_o;
  logic busy_o, valid_o, timeout_o;
  logic [2:0] chan_i = 0, addr_o, result_chan_o, lat_ch;
  logic [7:0] data_i, result_o;
  int checks = 0, fails = 0, conv_len = 1, mcnt;
  bit no_fall = 0, kill = 0, cv_q;

  always #4 clk = ~clk;

  adc_seq #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC),
            .TIMEOUT_CYC(TIMEOUT_CYC)) i_adc_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .busy_o(busy_o),
    .addr_o(addr_o), .latch_o(latch_o), .convst_o(convst_o), .oe_o(oe_o),
    .eoc_i(eoc_i), .data_i(data_i), .result_o(result_o), .result_chan_o(result_chan_o),
    .valid_o(valid_o), .timeout_o(timeout_o));

  function automatic logic [8-1:0] sample(input logic [2:0] ch);
    return 8'h11 * ch + 8'h05;
  endfunction

  always @(posedge clk) begin
    cv_q <= convst_o;
    if (latch_o) lat_ch <= addr_o;
    if (!rst_n || kill) begin eoc_i <= 1'b1; mcnt <= 0; end
    else if (convst_o && !cv_q && !no_fall) begin eoc_i <= 1'b0; mcnt <= conv_len; end
    else if (mcnt > 0) begin mcnt <= mcnt - 1; if (mcnt == 1) eoc_i <= 1'b1; end
  end
  assign data_i = oe_o ? sample(lat_ch) : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic run_conv(input logic [2:0] ch, input int clen, input bit intrude);
    int nset = 0, nlat = 0, nst = 0, noe = 0, cyc = 0;
    bit seen_lat = 0, order_ok = 1, eoc_low = 0, oe_early = 0, addr_bad = 0, got = 0;
    conv_len = clen;
    @(negedge clk); start_i = 1; chan_i = ch;
    @(negedge clk); start_i = 0;
    chk(busy_o && !timeout_o, "R8 busy on accept", busy_o, 1);
    while (cyc < 1000 && !got) begin
      if (intrude && cyc == 4) begin start_i = 1; chan_i = ~ch; end
      else start_i = 0;
      if (busy_o && addr_o != ch) addr_bad = 1;
      if (!seen_lat && busy_o && !latch_o) nset++;
      if (latch_o) begin seen_lat = 1; nlat++; end
      if (convst_o && nst == 0 && (nlat == 0 || latch_o)) order_ok = 0;
      if (convst_o) nst++;
      if (!eoc_i && nst > 0) eoc_low = 1;
      if (oe_o && noe == 0 && (!eoc_low || !eoc_i)) oe_early = 1;
      if (oe_o) noe++;
      if (valid_o) begin
        got = 1;
        chk(result_o == sample(ch), "R7 result byte", result_o, sample(ch));
        chk(result_chan_o == ch, "R8 channel kept", result_chan_o, ch);
        chk(!busy_o, "R8 busy low at valid", busy_o, 0);
      end else begin
        cyc++;
        @(negedge clk);
      end
    end
    start_i = 0;
    chk(got, "R10 conversion completes", got, 1);
    chk(nset == SETUP_CYC, "R3 setup cycles", nset, SETUP_CYC);
    chk(nlat == PULSE_CYC, "R3 latch width", nlat, PULSE_CYC);
    chk(nst == PULSE_CYC, "R4 start width", nst, PULSE_CYC);
    chk(order_ok, "R4 start after latch", order_ok, 1);
    chk(!oe_early, "R5 two-phase wait", oe_early, 0);
    chk(noe == SETTLE_CYC, "R6 oe width", noe, SETTLE_CYC);
    chk(!addr_bad, "R2 address equals channel", addr_bad, 0);
    @(negedge clk);
    chk(!valid_o, "R7 single-cycle valid", valid_o, 0);
    chk(result_o == sample(ch) && result_chan_o == ch, "R7 result held", result_o, sample(ch));
  endtask

  task automatic run_timeout(input bit nf, input int clen, input string tag);
    int nbusy = 0;
    no_fall = nf; conv_len = clen; kill = 0;
    @(negedge clk); start_i = 1; chan_i = 3'd6;
    @(negedge clk); start_i = 0;
    chk(!timeout_o, "R9 flag cleared on accept", timeout_o, 0);
    while (busy_o && nbusy < 1000) begin
      nbusy++;
      chk(!valid_o, "R9 no result on abort", valid_o, 0);
      @(negedge clk);
    end
    chk(nbusy == SETUP_CYC + 2 * PULSE_CYC + TIMEOUT_CYC, tag, nbusy,
        SETUP_CYC + 2 * PULSE_CYC + TIMEOUT_CYC);
    chk(timeout_o && !latch_o && !convst_o && !oe_o, "R9 abort state", timeout_o, 1);
    no_fall = 0; kill = 1;
    @(negedge clk); kill = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!latch_o && !convst_o && !oe_o, "R1 controls low", {latch_o, convst_o, oe_o}, 0);
    chk(!busy_o && !valid_o && !timeout_o, "R1 status low", {busy_o, valid_o, timeout_o}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_conv(VCH[i], VLEN[i], i == 3);
    run_timeout(1'b1, 1, "R9 abort in fall phase");
    run_timeout(1'b0, 100000, "R9 abort in rise phase");
    run_conv(3'd3, 4, 1'b0);
    chk(!timeout_o, "R10 restart after timeout", timeout_o, 0);
    @(negedge clk); start_i = 1; chan_i = 3'd7;
    @(negedge clk); start_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!busy_o && !latch_o && !convst_o && !oe_o, "R1 reset mid-run", busy_o, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule